// File: doc/BRIEF.md
# Configuration request TLP packetizer

This block turns one configuration access request into a PCIe configuration read or write transaction-layer packet. It sends the packet on a 64-bit root-port transmit stream. A request names the target bus, the device/function, a register offset, four byte enables, one write data dword and a read/write flag. The block compares the target bus with the root bus number it tracks. A match gives a Type 0 request and any other bus gives Type 1. It builds the three header dwords and sends them, together with the data dword, as two or three 64-bit beats flagged with start-of-packet and end-of-packet.

A requester presents a request while `busy` is low. The block then drives each beat and holds it until the stream takes it. After the last beat is taken, `done` pulses for one cycle. The packing depends on the offset. A write to a quadword-aligned offset puts the third header dword and the data dword in separate beats. Every other request puts them together in one beat. A Type 0 write to the primary-bus-number register changes the tracked root bus number, and that new number sets the type and requester ID of the requests that follow.

Top module: `cfg_tlp_packetizer`

## Requirements
- R1: After reset `tx_valid`, `busy` and `done` are 0 and the tracked root bus number is 0, so a request to bus 0 is Type 0 with requester ID upper byte 0.
- R2: The format/type byte is 0x04 for a read or 0x44 for a write when the target bus equals the root bus number. It is 0x05 for a read or 0x45 for a write on any other bus.
- R3: Header dword 0 holds the format/type byte in bits 31:24 and a length of 1 in bits 9:0. All other bits are zero.
- R4: Header dword 1 holds the requester ID {root bus, devfn} in bits 31:16, the tag in bits 15:8 (0x1D for reads, 0x10 for writes) and {4'b0, byte enables} in bits 7:0.
- R5: Header dword 2 holds the bus in bits 31:24, the devfn in bits 23:16 and the offset in bits 11:0, with offset bits 1:0 forced to zero. Bits 15:12 are zero.
- R6: The first beat is {dword 1, dword 0} with start-of-packet set and end-of-packet clear.
- R7: A write whose offset has bits 2:0 zero sends three beats. The second beat is {32'h0, dword 2} with no markers. The third beat is {32'h0, data} with end-of-packet set.
- R8: Every other write, and every read, sends two beats. The second beat is {data, dword 2} with end-of-packet set, where the data is zero for a read.
- R9: While `tx_valid` is high and `tx_ready` is low, the beat data and the markers stay unchanged.
- R10: A request is taken only when `req_valid` is high while `busy` is low. `busy` goes high in the cycle after acceptance. A `req_valid` raised while busy produces no packet.
- R11: `done` is high for exactly the one cycle after the end-of-packet beat is taken. In that cycle `busy` and `tx_valid` are low.
- R12: After the end-of-packet beat of a Type 0 write to offset 0x18 is taken, the root bus number becomes the low byte of the write data. Later requests use the new value for R2 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = configuration write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device/function |
| req_offset | input | 12 | Register offset (bits 1:0 ignored) |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Packet in progress; requests ignored |
| done | output | 1 | One-cycle pulse after the last beat is taken |
| tx_data | output | 64 | Beat data, lower dword first |
| tx_sop | output | 1 | Start-of-packet marker |
| tx_eop | output | 1 | End-of-packet marker |
| tx_valid | output | 1 | Beat valid |
| tx_ready | input | 1 | Stream accepts the beat |

## Verification
Once a request is accepted at a clock edge, the first beat and `busy` appear one cycle later. Each following beat appears one cycle after the previous beat is taken. `done` follows one cycle after the end-of-packet handshake, and a root bus update is visible in the next request. The bench drives its inputs and samples at the falling edge, sets `tx_ready` at random to force stalls, and records a beat only at a falling edge where both `tx_valid` and `tx_ready` are high. It then checks `done`, `busy` and `tx_valid` at the next falling edge and again one cycle after that.

// File: rtl/cfgtlp_pkg.sv
package cfgtlp_pkg;
  localparam int DW_W   = 32;
  localparam int BEAT_W = 2 * DW_W;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR01, ST_HDR2, ST_DATA} beat_st_e;

  typedef struct packed {
    logic        wr;
    logic [7:0]  bus;
    logic [7:0]  devfn;
    logic [11:0] off;
    logic [3:0]  be;
    logic [31:0] wdata;
  } cfg_req_t;

  function automatic logic [7:0] fmt_type(input logic wr, input logic type0);
    logic [7:0] f;
    f = wr ? 8'h44 : 8'h04;
    if (!type0) f = f | 8'h01;
    return f;
  endfunction

  function automatic logic [31:0] mk_dw0(input logic [7:0] ft);
    return {ft, 14'h0, 10'd1};
  endfunction

  function automatic logic [31:0] mk_dw1(input logic [7:0] rbus, input logic [7:0] devfn,
                                         input logic [7:0] tag, input logic [3:0] be);
    return {rbus, devfn, tag, 4'h0, be};
  endfunction

  function automatic logic [31:0] mk_dw2(input logic [7:0] bus, input logic [7:0] devfn,
                                         input logic [11:0] off);
    return {bus, devfn, 4'h0, off[11:2], 2'b00};
  endfunction
endpackage

// File: rtl/cfgtlp_hdr_build.sv
module cfgtlp_hdr_build
  import cfgtlp_pkg::*;
#(
  parameter logic [7:0]  RD_TAG      = 8'h1D,
  parameter logic [7:0]  WR_TAG      = 8'h10,
  parameter logic [11:0] PRI_BUS_OFF = 12'h018
) (
  input  cfg_req_t          req,
  input  logic [7:0]        root_bus,
  output logic [DW_W-1:0]   dw0,
  output logic [DW_W-1:0]   dw1,
  output logic [DW_W-1:0]   dw2,
  output logic              split_data,
  output logic              hits_pri_bus
);
  logic        type0;
  logic [11:0] off_dw;

  always_comb begin
    off_dw       = req.off & 12'hFFC;
    type0        = (req.bus == root_bus);
    dw0          = mk_dw0(fmt_type(req.wr, type0));
    dw1          = mk_dw1(root_bus, req.devfn, req.wr ? WR_TAG : RD_TAG, req.be);
    dw2          = mk_dw2(req.bus, req.devfn, off_dw);
    split_data   = req.wr && (off_dw[2:0] == 3'b000);
    hits_pri_bus = req.wr && type0 && (off_dw == (PRI_BUS_OFF & 12'hFFC));
  end
endmodule

// File: rtl/cfgtlp_beat_seq.sv
module cfgtlp_beat_seq
  import cfgtlp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              split_data,
  input  logic              wr,
  input  logic [DW_W-1:0]   dw0,
  input  logic [DW_W-1:0]   dw1,
  input  logic [DW_W-1:0]   dw2,
  input  logic [DW_W-1:0]   wdata,
  input  logic              tx_ready,
  output logic [BEAT_W-1:0] tx_data,
  output logic              tx_sop,
  output logic              tx_eop,
  output logic              tx_valid,
  output logic              busy,
  output logic              done,
  output logic              eop_fire
);
  beat_st_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        ST_IDLE:  if (start) st_q <= ST_HDR01;
        ST_HDR01: if (tx_ready) st_q <= ST_HDR2;
        ST_HDR2:  if (tx_ready) begin
                    if (split_data) st_q <= ST_DATA;
                    else begin
                      st_q <= ST_IDLE;
                      done <= 1'b1;
                    end
                  end
        ST_DATA:  if (tx_ready) begin
                    st_q <= ST_IDLE;
                    done <= 1'b1;
                  end
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    tx_valid = (st_q != ST_IDLE);
    busy     = tx_valid;
    tx_sop   = 1'b0;
    tx_eop   = 1'b0;
    tx_data  = '0;
    case (st_q)
      ST_HDR01: begin
        tx_data = {dw1, dw0};
        tx_sop  = 1'b1;
      end
      ST_HDR2: begin
        if (split_data) tx_data = {{DW_W{1'b0}}, dw2};
        else begin
          tx_data = {(wr ? wdata : {DW_W{1'b0}}), dw2};
          tx_eop  = 1'b1;
        end
      end
      ST_DATA: begin
        tx_data = {{DW_W{1'b0}}, wdata};
        tx_eop  = 1'b1;
      end
      default: ;
    endcase
    eop_fire = tx_valid && tx_ready && tx_eop;
  end
endmodule

// File: rtl/cfgtlp_rootbus_track.sv
module cfgtlp_rootbus_track #(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             update,
  input  logic [BUS_W-1:0] new_bus,
  output logic [BUS_W-1:0] root_bus
);
  always_ff @(posedge clk) begin
    if (!rst_n)      root_bus <= '0;
    else if (update) root_bus <= new_bus;
  end
endmodule

// File: rtl/cfg_tlp_packetizer.sv
module cfg_tlp_packetizer
  import cfgtlp_pkg::*;
#(
  parameter logic [7:0]  RD_TAG      = 8'h1D,
  parameter logic [7:0]  WR_TAG      = 8'h10,
  parameter logic [11:0] PRI_BUS_OFF = 12'h018
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [7:0]  req_bus,
  input  logic [7:0]  req_devfn,
  input  logic [11:0] req_offset,
  input  logic [3:0]  req_be,
  input  logic [31:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [63:0] tx_data,
  output logic        tx_sop,
  output logic        tx_eop,
  output logic        tx_valid,
  input  logic        tx_ready
);
  cfg_req_t        req_q;
  logic            req_accept;
  logic            eop_fire;
  logic            root_update;
  logic [7:0]      root_bus_q;
  logic [DW_W-1:0] dw0, dw1, dw2;
  logic            split_data, hits_pri_bus;

  assign req_accept  = req_valid && !busy;
  assign root_update = eop_fire && hits_pri_bus;

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= '0;
    else if (req_accept)
      req_q <= '{wr: req_write, bus: req_bus, devfn: req_devfn, off: req_offset,
                 be: req_be, wdata: req_wdata};
  end

  cfgtlp_hdr_build #(.RD_TAG(RD_TAG), .WR_TAG(WR_TAG), .PRI_BUS_OFF(PRI_BUS_OFF)) hdr_i (
    .req(req_q), .root_bus(root_bus_q), .dw0(dw0), .dw1(dw1), .dw2(dw2),
    .split_data(split_data), .hits_pri_bus(hits_pri_bus)
  );

  cfgtlp_beat_seq seq_i (
    .clk(clk), .rst_n(rst_n), .start(req_accept), .split_data(split_data),
    .wr(req_q.wr), .dw0(dw0), .dw1(dw1), .dw2(dw2), .wdata(req_q.wdata),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop),
    .tx_valid(tx_valid), .busy(busy), .done(done), .eop_fire(eop_fire)
  );

  cfgtlp_rootbus_track #(.BUS_W(8)) rb_i (
    .clk(clk), .rst_n(rst_n), .update(root_update), .new_bus(req_q.wdata[7:0]),
    .root_bus(root_bus_q)
  );
endmodule

// File: rtl/cfgtlp_checker.sv
module cfgtlp_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        busy,
  input logic        done,
  input logic [63:0] tx_data,
  input logic        tx_sop,
  input logic        tx_eop,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic        eop_fire,
  input logic        root_update,
  input logic [7:0]  root_bus_q
);
  // R9
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop)));
  // R11
  a_r11_done_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
    eop_fire |=> (done && !busy && !tx_valid));
  // R11
  a_r11_done_only_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(tx_valid && tx_ready && tx_eop));
  // R6
  a_r6_markers_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !(tx_sop && tx_eop));
  // R10
  a_r10_accept_starts_packet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> (busy && tx_valid && tx_sop));
  // R6
  a_r6_sop_then_more: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_sop) |=> (tx_valid && !tx_sop));
  // R12
  a_r12_root_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !root_update |=> $stable(root_bus_q));
endmodule

bind cfg_tlp_packetizer cfgtlp_checker chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
  .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .eop_fire(eop_fire), .root_update(root_update),
  .root_bus_q(root_bus_q)
);

// File: tb/cfg_tlp_packetizer_tb_top.sv
`timescale 1ns/1ps
module cfg_tlp_packetizer_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [7:0]  req_bus = 0, req_devfn = 0;
  logic [11:0] req_offset = 0;
  logic [3:0]  req_be = 0;
  logic [31:0] req_wdata = 0;
  logic        busy, done, tx_sop, tx_eop, tx_valid;
  logic [63:0] tx_data;
  logic        tx_ready = 0;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] m_root = 0;

  always #4 clk = ~clk;

  cfg_tlp_packetizer dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_bus(req_bus), .req_devfn(req_devfn), .req_offset(req_offset), .req_be(req_be),
    .req_wdata(req_wdata), .busy(busy), .done(done), .tx_data(tx_data), .tx_sop(tx_sop),
    .tx_eop(tx_eop), .tx_valid(tx_valid), .tx_ready(tx_ready)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] e_fmt(input logic wr, input logic [7:0] bus);
    if (bus == m_root) return wr ? 8'h44 : 8'h04;
    return wr ? 8'h45 : 8'h05;
  endfunction

  task automatic run_req(input logic wr, input logic [7:0] bus, input logic [7:0] devfn,
                         input logic [11:0] off, input logic [3:0] be, input logic [31:0] wd,
                         input int stall_pct, input bit inject);
    logic [63:0] cap_d [3];
    logic        cap_s [3];
    logic        cap_e [3];
    logic [31:0] e0, e1, e2;
    logic [63:0] prev_d;
    logic        prev_s, prev_e, prev_stall;
    int n, cyc;
    bit three;
    e0 = {e_fmt(wr, bus), 24'h000001};
    e1 = {m_root, devfn, (wr ? 8'h10 : 8'h1D), 4'h0, be};
    e2 = {bus, devfn, 4'h0, off[11:2], 2'b00};
    three = wr && (off[2] == 1'b0);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_bus = bus; req_devfn = devfn;
    req_offset = off; req_be = be; req_wdata = wd;
    @(negedge clk);
    req_valid = 0; req_wdata = ~wd; req_bus = ~bus;
    chk("R10 busy after accept", busy, 1);
    n = 0; cyc = 0; prev_stall = 0; prev_d = 0; prev_s = 0; prev_e = 0;
    forever begin
      if (prev_stall) chk("R9 held beat", {tx_data[62:0], tx_sop ^ tx_eop},
                          {prev_d[62:0], prev_s ^ prev_e});
      if (prev_stall) chk("R9 held data", tx_data, prev_d);
      tx_ready = ($urandom_range(99) >= stall_pct);
      if (inject && cyc == 0) begin
        tx_ready = 0;
        req_valid = 1; req_write = 1; req_bus = 8'hEE; req_offset = 12'h018;
      end else req_valid = 0;
      if (tx_valid && tx_ready && n < 3) begin
        cap_d[n] = tx_data; cap_s[n] = tx_sop; cap_e[n] = tx_eop; n++;
        if (tx_eop) break;
      end
      prev_stall = tx_valid && !tx_ready;
      prev_d = tx_data; prev_s = tx_sop; prev_e = tx_eop;
      cyc++;
      if (cyc > 200) break;
      @(negedge clk);
    end
    req_valid = 0;
    @(negedge clk);
    tx_ready = 0;
    chk("R11 done pulse", {done, busy, tx_valid}, 3'b100);
    @(negedge clk);
    chk("R11 done one cycle", done, 0);
    chk("R10 no extra packet", tx_valid, 0);
    chk(three ? "R7 beat count" : "R8 beat count", n, three ? 3 : 2);
    if (n >= 2) begin
      chk("R2 format type", cap_d[0][31:24], e_fmt(wr, bus));
      chk("R3 dword0", cap_d[0][31:0], e0);
      chk("R4 dword1", cap_d[0][63:32], e1);
      if (m_root != 0) chk("R12 requester root", cap_d[0][63:56], m_root);
      chk("R5 dword2", cap_d[1][31:0], e2);
      chk("R6 first beat", {cap_d[0], cap_s[0], cap_e[0]}, {e1, e0, 2'b10});
      if (three) begin
        chk("R7 beat2", {cap_d[1], cap_s[1], cap_e[1]}, {32'h0, e2, 2'b00});
        if (n == 3) chk("R7 beat3", {cap_d[2], cap_s[2], cap_e[2]}, {32'h0, wd, 2'b01});
      end else
        chk("R8 beat2", {cap_d[1], cap_s[1], cap_e[1]}, {(wr ? wd : 32'h0), e2, 2'b01});
    end
    if (wr && bus == m_root && off[11:2] == 10'd6) m_root = wd[7:0];
  endtask

  initial begin
    int cnt = 0;
    while (!finished) begin
      @(posedge clk);
      cnt++;
      if (cnt > 150000) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected<150000", cnt);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset outputs", {tx_valid, busy, done}, 3'b000);
    run_req(0, 8'h00, 8'h08, 12'h010, 4'hF, 32'hDEAD_BEEF, 0, 0);
    run_req(1, 8'h00, 8'h10, 12'h008, 4'h3, 32'h1234_5678, 30, 0);
    run_req(1, 8'h00, 8'h10, 12'h00C, 4'hC, 32'hA5A5_0F0F, 50, 0);
    run_req(0, 8'h03, 8'h21, 12'h013, 4'h2, 32'h0, 40, 0);
    run_req(1, 8'h03, 8'h00, 12'h018, 4'h1, 32'h0000_0009, 0, 0);
    run_req(1, 8'h00, 8'h00, 12'h018, 4'h1, 32'h0000_0005, 20, 0);
    run_req(0, 8'h05, 8'h00, 12'h000, 4'hF, 32'h0, 0, 0);
    run_req(0, 8'h00, 8'h00, 12'h004, 4'hF, 32'h0, 0, 1);
    run_req(1, 8'h05, 8'h40, 12'hFFC, 4'hF, 32'hFFFF_FFFF, 60, 1);
    for (int i = 0; i < 80; i++) begin
      logic [7:0] b;
      logic [11:0] o;
      case ($urandom_range(2))
        0: b = m_root;
        1: b = 8'(m_root + 1);
        default: b = 8'($urandom);
      endcase
      o = ($urandom_range(9) == 0) ? 12'h018 : 12'($urandom);
      run_req(1'($urandom), b, 8'($urandom), o, 4'($urandom), $urandom,
              $urandom_range(70), ($urandom_range(7) == 0));
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule